// File: doc/BRIEF.md
# Debug Memory Access Port Controller

This block sits behind a debugger's register port and turns accesses to a data register into single memory reads and writes on a one-beat request/response master interface. A control word sets up each transfer: the size of the access, the protection, cache and shareability attributes driven on the bus, the operating mode, the address-advance policy and the error policy. The block also keeps a transfer address register and a data register, and it shows the state of the authentication pins as read-only status bits.

Before it issues a transfer, the block checks the authentication pins, the secure or non-secure nature of the access, the legality of the size, mode and cache/shareability settings, and whether a stop-on-error condition is in force. A refused transfer never reaches the bus. It completes at once and reports a memory access error. An accepted transfer holds its request until the bus acknowledges it or the debugger aborts it. The address advances by the access size only when the transfer ends cleanly.

The register port selects one of four registers: 0 is the control word, 1 is the transfer address, 2 is data (reading or writing it starts a transfer), and 3 is the error register (bit 0 is the sticky error flag, and writing 1 to it clears the flag). `reg_done` pulses for one cycle when a data access finishes. `reg_err` is high in that same cycle when the access failed and errors are passed upstream.

Top module: `dbg_mem_port`

## Requirements
- R1: After reset the control word reads 0x30006002 when all four enable pins are low: protection 3'b011 in bits 30:28, shareability 2'b11 in bits 14:13, size 3'b010 in bits 2:0, and every other field zero. The address register reads 0 and no request is raised.
- R2: Bits 31, 22:18, 15 and 3 of the control word always read 0, and writes to them have no effect. Writing all ones while the enables are low reads back 0x7F037F37.
- R3: Control bit 6 reads as `dbg_en | nid_en`. A bus request is only ever raised while `dbg_en` is high. When `dbg_en` is low, a data access completes with an error and no request.
- R4: Control bit 23 reads as `sec_en | secnid_en`. An access is secure when protection bit 1 (bit 29) is 0. A secure access is issued only when both `dbg_en` and `sec_en` are high. A non-secure access needs only `dbg_en`.
- R5: While a request is outstanding, `m_arprot` and `m_awprot` both carry the protection field, `m_cache` carries bits 27:24, `m_domain` carries bits 14:13 and `m_size` carries bits 2:0. The request, address and attributes all stay stable until the request is acknowledged or aborted.
- R6: Size 0, 1 and 2 select 1, 2 and 4 bytes. Size 3 selects 8 bytes only when LARGE_DATA is 1. Any other size, and any nonzero mode (bits 11:8), is refused with an error and no request.
- R7: A cache/shareability pair is legal only when cache bit 1 (bit 25) is 0 exactly when shareability is 2'b11. An illegal pair is refused with an error and no request.
- R8: When the increment field (bits 5:4) is 1, a transfer acknowledged without error adds the access size in bytes to the address, wrapping at AW bits. The address stays unchanged after an error response, an abort, or any other increment value.
- R9: Control bit 7 reads 1 exactly while a request is outstanding. An acknowledge or abort drops the request at the next edge, and `reg_done` pulses in the cycle that follows that edge.
- R10: Any refused access or error response sets the sticky flag (register 3, bit 0). Only a write of 1 to that bit clears it. While the flag is set and bit 17 is 1, data accesses complete at once with an error and no request.
- R11: When bit 16 is 1, `reg_err` stays low at completion even for a failed access, and the sticky flag is still set.
- R12: While a request is outstanding, writes to the control word, the address and data, and new data accesses, are all ignored.
- R13: A data write drives the written value on `m_wdata` with `m_write` high. A clean data read captures `m_rdata` into the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| reg_sel | input | 2 | Register select: 0 control, 1 address, 2 data, 3 error |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (starts a transfer when it selects data) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| reg_done | output | 1 | One-cycle pulse when a data access completes |
| reg_err | output | 1 | Failed completion, qualified by the pass-upstream policy |
| dbg_en | input | 1 | Invasive debug enable |
| nid_en | input | 1 | Non-invasive debug enable |
| sec_en | input | 1 | Secure invasive debug enable |
| secnid_en | input | 1 | Secure non-invasive debug enable |
| m_req | output | 1 | Bus request, held until acknowledge or abort |
| m_write | output | 1 | 1 for a write transfer |
| m_addr | output | AW | Transfer address |
| m_wdata | output | 32 | Write data |
| m_size | output | 3 | Access size code |
| m_arprot | output | 3 | Read protection attributes |
| m_awprot | output | 3 | Write protection attributes |
| m_cache | output | 4 | Cache attributes |
| m_domain | output | 2 | Shareability attributes |
| m_ack | input | 1 | Bus acknowledge |
| m_err | input | 1 | Error response, valid with acknowledge |
| m_rdata | input | 32 | Read data, valid with acknowledge |
| m_abort | input | 1 | Abort of the outstanding transfer (takes priority over acknowledge) |

## Verification
The bench builds the block with AW = 16 and LARGE_DATA = 1. The 8-byte size code is therefore a legal access whose increment of 8 can be checked, size 4 serves as the reserved case, and an address of 0xFFFC plus 4 shows the wrap back to 0 within a few cycles. Scenarios cover the authentication combinations and secure versus non-secure protection, illegal attribute pairs, error responses, aborts, and the stop-on-error and error-pass policies.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

  localparam int REG_W = 32;

  localparam logic [1:0] SEL_CTL  = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_ERR  = 2'd3;

  typedef struct packed {
    logic [2:0] prot;
    logic [3:0] cache;
    logic       err_stop;
    logic       err_nopass;
    logic [1:0] domain;
    logic       coh_en;
    logic [3:0] mode;
    logic [1:0] inc_mode;
    logic [2:0] size;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{prot: 3'b011, cache: 4'h0, err_stop: 1'b0,
                                 err_nopass: 1'b0, domain: 2'b11, coh_en: 1'b0,
                                 mode: 4'h0, inc_mode: 2'b00, size: 3'b010};

  function automatic ctl_t ctl_from_word(input logic [REG_W-1:0] w);
    ctl_t c;
    c.prot       = w[30:28];
    c.cache      = w[27:24];
    c.err_stop   = w[17];
    c.err_nopass = w[16];
    c.domain     = w[14:13];
    c.coh_en     = w[12];
    c.mode       = w[11:8];
    c.inc_mode   = w[5:4];
    c.size       = w[2:0];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] ctl_to_word(input ctl_t c, input logic sdev,
                                                   input logic inprog, input logic dev);
    return {1'b0, c.prot, c.cache, sdev, 5'b0, c.err_stop, c.err_nopass, 1'b0,
            c.domain, c.coh_en, c.mode, inprog, dev, c.inc_mode, 1'b0, c.size};
  endfunction

  function automatic logic [3:0] size_bytes(input logic [2:0] size);
    return 4'd1 << size[1:0];
  endfunction

  function automatic logic size_legal(input logic [2:0] size, input logic large_ok);
    return (size <= 3'd2) || (size == 3'd3 && large_ok);
  endfunction

  function automatic logic attr_legal(input logic [3:0] cache, input logic [1:0] domain);
    return (cache[1] == 1'b0) == (domain == 2'b11);
  endfunction

endpackage

// File: rtl/dmp_ctl_reg.sv
module dmp_ctl_reg
  import dmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output ctl_t             ctl_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= CTL_RESET;
    end else if (wr_en) begin
      ctl_q <= ctl_from_word(wdata);
    end
  end

endmodule

// File: rtl/dmp_access_gate.sv
module dmp_access_gate
  import dmp_pkg::*;
#(
  parameter bit LARGE_DATA = 1'b0
) (
  input  ctl_t ctl,
  input  logic dbg_en,
  input  logic sec_en,
  output logic auth_ok,
  output logic fmt_ok,
  output logic permit
);

  logic is_secure;

  always_comb begin
    is_secure = ~ctl.prot[1];
    auth_ok   = dbg_en & (~is_secure | sec_en);
    fmt_ok    = size_legal(ctl.size, LARGE_DATA) &
                attr_legal(ctl.cache, ctl.domain) &
                (ctl.mode == 4'h0);
    permit    = auth_ok & fmt_ok;
  end

endmodule

// File: rtl/dmp_xfer_engine.sv
module dmp_xfer_engine
  import dmp_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_write,
  input  logic             permit,
  input  logic             addr_wr,
  input  logic             clr_err,
  input  logic [REG_W-1:0] wdata,
  input  logic [2:0]       size,
  input  logic [1:0]       inc_mode,
  input  logic             err_stop,
  input  logic             bus_ack,
  input  logic             bus_err,
  input  logic             bus_abort,
  input  logic [REG_W-1:0] bus_rdata,
  output logic             busy,
  output logic             wr_q,
  output logic [AW-1:0]    addr_q,
  output logic [REG_W-1:0] data_q,
  output logic             sticky_q,
  output logic             done_q,
  output logic             done_err_q,
  output logic             stopped,
  output logic             clean_end
);

  logic [AW-1:0] addr_next;

  always_comb begin
    stopped   = sticky_q & err_stop;
    clean_end = busy & bus_ack & ~bus_abort & ~bus_err;
    addr_next = addr_q + AW'(size_bytes(size));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      wr_q       <= 1'b0;
      addr_q     <= '0;
      data_q     <= '0;
      sticky_q   <= 1'b0;
      done_q     <= 1'b0;
      done_err_q <= 1'b0;
    end else begin
      done_q     <= 1'b0;
      done_err_q <= 1'b0;
      if (addr_wr) addr_q <= wdata[AW-1:0];
      if (clr_err) sticky_q <= 1'b0;
      if (start) begin
        if (start_write) data_q <= wdata;
        if (stopped) begin
          done_q     <= 1'b1;
          done_err_q <= 1'b1;
        end else if (!permit) begin
          done_q     <= 1'b1;
          done_err_q <= 1'b1;
          sticky_q   <= 1'b1;
        end else begin
          busy <= 1'b1;
          wr_q <= start_write;
        end
      end else if (busy) begin
        if (bus_abort) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end else if (bus_ack) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
          if (bus_err) begin
            done_err_q <= 1'b1;
            sticky_q   <= 1'b1;
          end else begin
            if (!wr_q) data_q <= bus_rdata;
            if (inc_mode == 2'b01) addr_q <= addr_next;
          end
        end
      end
    end
  end

endmodule

// File: rtl/dbg_mem_port.sv
module dbg_mem_port
  import dmp_pkg::*;
#(
  parameter int AW         = 32,
  parameter bit LARGE_DATA = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          reg_done,
  output logic          reg_err,
  input  logic          dbg_en,
  input  logic          nid_en,
  input  logic          sec_en,
  input  logic          secnid_en,
  output logic          m_req,
  output logic          m_write,
  output logic [AW-1:0] m_addr,
  output logic [31:0]   m_wdata,
  output logic [2:0]    m_size,
  output logic [2:0]    m_arprot,
  output logic [2:0]    m_awprot,
  output logic [3:0]    m_cache,
  output logic [1:0]    m_domain,
  input  logic          m_ack,
  input  logic          m_err,
  input  logic [31:0]   m_rdata,
  input  logic          m_abort
);

  ctl_t             ctl;
  logic             busy;
  logic             wr_q;
  logic [AW-1:0]    addr_q;
  logic [REG_W-1:0] data_q;
  logic             sticky_q;
  logic             done_q;
  logic             done_err_q;
  logic             stopped;
  logic             clean_end;
  logic             auth_ok;
  logic             fmt_ok;
  logic             permit;
  logic             start_evt;
  logic             ctl_wr_evt;
  logic             addr_wr_evt;
  logic             clr_evt;
  logic             dev_on;
  logic             sdev_on;
  logic [REG_W-1:0] ctl_word;

  always_comb begin
    start_evt   = (reg_wr | reg_rd) & (reg_sel == SEL_DATA) & ~busy;
    ctl_wr_evt  = reg_wr & (reg_sel == SEL_CTL) & ~busy;
    addr_wr_evt = reg_wr & (reg_sel == SEL_ADDR) & ~busy;
    clr_evt     = reg_wr & (reg_sel == SEL_ERR) & reg_wdata[0];
    dev_on      = dbg_en | nid_en;
    sdev_on     = sec_en | secnid_en;
    ctl_word    = ctl_to_word(ctl, sdev_on, busy, dev_on);
  end

  dmp_ctl_reg u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (ctl_wr_evt),
    .wdata (reg_wdata),
    .ctl_q (ctl)
  );

  dmp_access_gate #(.LARGE_DATA(LARGE_DATA)) u_gate (
    .ctl     (ctl),
    .dbg_en  (dbg_en),
    .sec_en  (sec_en),
    .auth_ok (auth_ok),
    .fmt_ok  (fmt_ok),
    .permit  (permit)
  );

  dmp_xfer_engine #(.AW(AW)) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_evt),
    .start_write (reg_wr),
    .permit      (permit),
    .addr_wr     (addr_wr_evt),
    .clr_err     (clr_evt),
    .wdata       (reg_wdata),
    .size        (ctl.size),
    .inc_mode    (ctl.inc_mode),
    .err_stop    (ctl.err_stop),
    .bus_ack     (m_ack),
    .bus_err     (m_err),
    .bus_abort   (m_abort),
    .bus_rdata   (m_rdata),
    .busy        (busy),
    .wr_q        (wr_q),
    .addr_q      (addr_q),
    .data_q      (data_q),
    .sticky_q    (sticky_q),
    .done_q      (done_q),
    .done_err_q  (done_err_q),
    .stopped     (stopped),
    .clean_end   (clean_end)
  );

  always_comb begin
    unique case (reg_sel)
      SEL_CTL:  reg_rdata = ctl_word;
      SEL_ADDR: reg_rdata = REG_W'(addr_q);
      SEL_DATA: reg_rdata = data_q;
      default:  reg_rdata = {31'b0, sticky_q};
    endcase
    reg_done = done_q;
    reg_err  = done_err_q & ~ctl.err_nopass;
    m_req    = busy;
    m_write  = wr_q;
    m_addr   = addr_q;
    m_wdata  = data_q;
    m_size   = ctl.size;
    m_arprot = ctl.prot;
    m_awprot = ctl.prot;
    m_cache  = ctl.cache;
    m_domain = ctl.domain;
  end

endmodule

// File: rtl/dmp_checker.sv
module dmp_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dbg_en,
  input logic          sec_en,
  input logic          m_req,
  input logic          m_ack,
  input logic          m_err,
  input logic          m_abort,
  input logic [2:0]    m_arprot,
  input logic [AW-1:0] m_addr,
  input logic          reg_done,
  input logic          reg_err,
  input logic          start_evt,
  input logic          fmt_ok,
  input logic          sticky_q,
  input logic          err_stop,
  input logic          err_nopass
);

  // R3: a request only starts with invasive debug enabled
  p_req_auth_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_req) |-> $past(dbg_en));

  // R4: a secure request needs the secure enable
  p_secure_auth_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(m_req) && !m_arprot[1]) |-> $past(sec_en));

  // R5: request and its attributes hold until acknowledge or abort
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ack && !m_abort) |=> (m_req && $stable(m_addr) && $stable(m_arprot)));

  // R6, R7: bad format never reaches the bus
  p_fmt_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !fmt_ok) |=> (!m_req && reg_done));

  // R8: no address advance after an error response
  p_noinc_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_ack && m_err && !m_abort) |=> $stable(m_addr));

  // R9: completion drops the request and pulses done
  p_done_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && (m_ack || m_abort)) |=> (!m_req && reg_done));

  // R10: stop-on-error keeps the bus idle
  p_stop_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q && err_stop && !m_req) |=> !m_req);

  // R11: errors withheld when not passed upstream
  p_npass_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_done && $past(err_nopass)) |-> !reg_err);

endmodule

bind dbg_mem_port dmp_checker #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dbg_en     (dbg_en),
  .sec_en     (sec_en),
  .m_req      (m_req),
  .m_ack      (m_ack),
  .m_err      (m_err),
  .m_abort    (m_abort),
  .m_arprot   (m_arprot),
  .m_addr     (m_addr),
  .reg_done   (reg_done),
  .reg_err    (reg_err),
  .start_evt  (start_evt),
  .fmt_ok     (fmt_ok),
  .sticky_q   (sticky_q),
  .err_stop   (ctl.err_stop),
  .err_nopass (ctl.err_nopass)
);

// File: tb/dbg_mem_port_tb.sv
`timescale 1ns/1ps
module dbg_mem_port_tb;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    reg_sel = 2'd0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          reg_done, reg_err;
  logic          dbg_en = 1'b0, nid_en = 1'b0, sec_en = 1'b0, secnid_en = 1'b0;
  logic          m_req, m_write;
  logic [AW-1:0] m_addr;
  logic [31:0]   m_wdata;
  logic [2:0]    m_size, m_arprot, m_awprot;
  logic [3:0]    m_cache;
  logic [1:0]    m_domain;
  logic          m_ack = 1'b0, m_err = 1'b0, m_abort = 1'b0;
  logic [31:0]   m_rdata = '0;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dbg_mem_port #(.AW(AW), .LARGE_DATA(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_done(reg_done), .reg_err(reg_err),
    .dbg_en(dbg_en), .nid_en(nid_en), .sec_en(sec_en), .secnid_en(secnid_en),
    .m_req(m_req), .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_size(m_size), .m_arprot(m_arprot), .m_awprot(m_awprot), .m_cache(m_cache),
    .m_domain(m_domain), .m_ack(m_ack), .m_err(m_err), .m_rdata(m_rdata),
    .m_abort(m_abort)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [2:0] prot, input logic [3:0] cache,
                                     input logic [1:0] domain, input logic [1:0] inc,
                                     input logic [2:0] size, input logic stop,
                                     input logic np);
    return {1'b0, prot, cache, 1'b0, 5'b0, stop, np, 1'b0, domain, 1'b0, 4'b0,
            2'b00, inc, 1'b0, size};
  endfunction

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    reg_sel = sel; reg_wr = 1'b1; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] sel, output logic [31:0] val);
    reg_sel = sel;
    #1;
    val = reg_rdata;
  endtask

  // One data access; the bench plays the bus side.
  task automatic access(input bit wr, input logic [31:0] wd, input int delay,
                        input bit rerr, input logic [31:0] rd, input bit abrt,
                        output bit issued, output bit done, output bit err,
                        output bit inprog_ok);
    logic [31:0] v;
    @(negedge clk);
    reg_sel = 2'd2; reg_wr = wr; reg_rd = !wr; reg_wdata = wd;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    #1;
    issued = m_req;
    inprog_ok = 1'b1;
    if (!issued) begin
      done = reg_done; err = reg_err;
      return;
    end
    rd_reg(2'd0, v);
    if (v[7] !== 1'b1) inprog_ok = 1'b0;
    for (int i = 0; i < delay; i++) begin
      @(negedge clk);
      if (m_req !== 1'b1) inprog_ok = 1'b0;
    end
    if (abrt) m_abort = 1'b1;
    else begin m_ack = 1'b1; m_err = rerr; m_rdata = rd; end
    @(negedge clk);
    m_ack = 1'b0; m_err = 1'b0; m_abort = 1'b0;
    #1;
    done = reg_done; err = reg_err;
    rd_reg(2'd0, v);
    if (v[7] !== 1'b0 || m_req !== 1'b0) inprog_ok = 1'b0;
  endtask

  task automatic clear_err();
    wr_reg(2'd3, 32'h1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd_reg(2'd0, v); chk("R1 ctl reset", v, 32'h3000_6002);
    rd_reg(2'd1, v); chk("R1 addr reset", v, 32'h0);
    chk("R1 no req", {31'b0, m_req}, 32'h0);
  endtask

  task automatic t_raz();
    logic [31:0] v;
    wr_reg(2'd0, 32'hFFFF_FFFF);
    rd_reg(2'd0, v); chk("R2 raz bits", v, 32'h7F03_7F37);
    wr_reg(2'd0, 32'h3000_6002);
    rd_reg(2'd0, v); chk("R2 restore", v, 32'h3000_6002);
  endtask

  task automatic t_status();
    logic [31:0] v;
    nid_en = 1'b1; secnid_en = 1'b1;
    rd_reg(2'd0, v);
    chk("R3 dev bit", {31'b0, v[6]}, 32'h1);
    chk("R4 sdev bit", {31'b0, v[23]}, 32'h1);
    nid_en = 1'b0; secnid_en = 1'b0; sec_en = 1'b1;
    rd_reg(2'd0, v);
    chk("R4 sdev via sec_en", {31'b0, v[23]}, 32'h1);
    chk("R3 dev off", {31'b0, v[6]}, 32'h0);
    sec_en = 1'b0;
  endtask

  task automatic t_dev_off();
    bit is, dn, er, ip;
    nid_en = 1'b1; dbg_en = 1'b0;
    access(1'b1, 32'h1234, 0, 1'b0, 0, 1'b0, is, dn, er, ip);
    chk("R3 blocked no req", {31'b0, is}, 32'h0);
    chk("R3 blocked done+err", {30'b0, dn, er}, 32'h3);
    nid_en = 1'b0; dbg_en = 1'b1;
    clear_err();
  endtask

  task automatic t_write_nonsecure();
    bit is, dn, er, ip;
    logic [31:0] v;
    wr_reg(2'd0, mk(3'b011, 4'h0, 2'b11, 2'b00, 3'd2, 1'b0, 1'b0));
    wr_reg(2'd1, 32'h0100);
    @(negedge clk);
    reg_sel = 2'd2; reg_wr = 1'b1; reg_wdata = 32'hCAFE_0001;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R13 m_write", {31'b0, m_write}, 32'h1);
    chk("R13 m_wdata", m_wdata, 32'hCAFE_0001);
    chk("R5 arprot", {29'b0, m_arprot}, 32'h3);
    chk("R5 awprot", {29'b0, m_awprot}, 32'h3);
    chk("R5 domain/cache/size", {22'b0, m_domain, m_cache, m_size}, {22'b0, 2'b11, 4'h0, 3'd2});
    chk("R5 addr", {16'b0, m_addr}, 32'h0100);
    repeat (2) @(negedge clk);
    chk("R5 held", {31'b0, m_req}, 32'h1);
    m_ack = 1'b1;
    @(negedge clk);
    m_ack = 1'b0;
    chk("R9 done pulse", {30'b0, reg_done, m_req}, 32'h2);
    rd_reg(2'd1, v); chk("R8 inc off", v, 32'h0100);
    access(1'b0, 0, 1, 1'b0, 32'h5A5A_A5A5, 1'b0, is, dn, er, ip);
    chk("R9 trinprog", {31'b0, ip}, 32'h1);
    rd_reg(2'd2, v); chk("R13 read data", v, 32'h5A5A_A5A5);
  endtask

  task automatic t_secure();
    bit is, dn, er, ip;
    wr_reg(2'd0, mk(3'b001, 4'h0, 2'b11, 2'b00, 3'd2, 1'b0, 1'b0));
    sec_en = 1'b0;
    access(1'b0, 0, 0, 1'b0, 0, 1'b0, is, dn, er, ip);
    chk("R4 secure refused", {29'b0, is, dn, er}, 32'h3);
    clear_err();
    sec_en = 1'b1;
    access(1'b0, 0, 0, 1'b0, 32'h77, 1'b0, is, dn, er, ip);
    chk("R4 secure issued", {29'b0, is, dn, er}, 32'h6);
    sec_en = 1'b0;
  endtask

  task automatic t_increment();
    bit is, dn, er, ip;
    logic [31:0] v;
    logic [15:0] exp;
    exp = 16'h0200;
    wr_reg(2'd1, 32'h0200);
    for (int s = 0; s < 4; s++) begin
      wr_reg(2'd0, mk(3'b011, 4'h0, 2'b11, 2'b01, 3'(s), 1'b0, 1'b0));
      access(1'b1, 32'h1, 0, 1'b0, 0, 1'b0, is, dn, er, ip);
      exp = exp + (16'd1 << s);
      rd_reg(2'd1, v); chk($sformatf("R8 R6 inc size %0d", s), v, {16'b0, exp});
    end
    wr_reg(2'd1, 32'hFFFC);
    wr_reg(2'd0, mk(3'b011, 4'h0, 2'b11, 2'b01, 3'd2, 1'b0, 1'b0));
    access(1'b1, 32'h1, 0, 1'b0, 0, 1'b0, is, dn, er, ip);
    rd_reg(2'd1, v); chk("R8 wrap", v, 32'h0);
    access(1'b1, 32'h1, 0, 1'b1, 0, 1'b0, is, dn, er, ip);
    chk("R8 err resp reported", {31'b0, er}, 32'h1);
    rd_reg(2'd1, v); chk("R8 no inc on err", v, 32'h0);
    clear_err();
    access(1'b1, 32'h1, 1, 1'b0, 0, 1'b1, is, dn, er, ip);
    chk("R8 abort done no err", {30'b0, dn, er}, 32'h2);
    rd_reg(2'd1, v); chk("R8 no inc on abort", v, 32'h0);
  endtask

  task automatic t_format();
    bit is, dn, er, ip;
    logic [31:0] v;
    wr_reg(2'd0, mk(3'b011, 4'h0, 2'b11, 2'b00, 3'd4, 1'b0, 1'b0));
    access(1'b0, 0, 0, 1'b0, 0, 1'b0, is, dn, er, ip);
    chk("R6 reserved size", {29'b0, is, dn, er}, 32'h3);
    clear_err();
    wr_reg(2'd0, mk(3'b011, 4'h0, 2'b11, 2'b00, 3'd2, 1'b0, 1'b0) | 32'h0000_0100);
    access(1'b0, 0, 0, 1'b0, 0, 1'b0, is, dn, er, ip);
    chk("R6 nonzero mode", {29'b0, is, dn, er}, 32'h3);
    clear_err();
    wr_reg(2'd0, mk(3'b011, 4'h2, 2'b11, 2'b00, 3'd2, 1'b0, 1'b0));
    access(1'b0, 0, 0, 1'b0, 0, 1'b0, is, dn, er, ip);
    chk("R7 cacheable system", {29'b0, is, dn, er}, 32'h3);
    clear_err();
    wr_reg(2'd0, mk(3'b011, 4'h0, 2'b01, 2'b00, 3'd2, 1'b0, 1'b0));
    access(1'b0, 0, 0, 1'b0, 0, 1'b0, is, dn, er, ip);
    chk("R7 device inner", {29'b0, is, dn, er}, 32'h3);
    rd_reg(2'd3, v); chk("R10 sticky set", v, 32'h1);
    clear_err();
    rd_reg(2'd3, v); chk("R10 sticky cleared", v, 32'h0);
    wr_reg(2'd0, mk(3'b011, 4'h2, 2'b01, 2'b00, 3'd2, 1'b0, 1'b0));
    access(1'b0, 0, 0, 1'b0, 0, 1'b0, is, dn, er, ip);
    chk("R7 legal cacheable inner", {29'b0, is, dn, er}, 32'h6);
  endtask

  task automatic t_stop();
    bit is, dn, er, ip;
    wr_reg(2'd0, mk(3'b011, 4'h0, 2'b11, 2'b00, 3'd2, 1'b1, 1'b0));
    access(1'b0, 0, 0, 1'b1, 0, 1'b0, is, dn, er, ip);
    chk("R10 err resp", {29'b0, is, dn, er}, 32'h7);
    access(1'b0, 0, 0, 1'b0, 0, 1'b0, is, dn, er, ip);
    chk("R10 stopped", {29'b0, is, dn, er}, 32'h3);
    clear_err();
    access(1'b0, 0, 0, 1'b0, 0, 1'b0, is, dn, er, ip);
    chk("R10 resumed", {29'b0, is, dn, er}, 32'h6);
  endtask

  task automatic t_npass();
    bit is, dn, er, ip;
    logic [31:0] v;
    wr_reg(2'd0, mk(3'b011, 4'h0, 2'b11, 2'b00, 3'd5, 1'b0, 1'b1));
    access(1'b0, 0, 0, 1'b0, 0, 1'b0, is, dn, er, ip);
    chk("R11 err withheld", {29'b0, is, dn, er}, 32'h2);
    rd_reg(2'd3, v); chk("R11 sticky still set", v, 32'h1);
    clear_err();
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    wr_reg(2'd0, mk(3'b011, 4'h0, 2'b11, 2'b00, 3'd2, 1'b0, 1'b0));
    wr_reg(2'd1, 32'h0040);
    wr_reg(2'd2, 32'hAAAA_0000);
    chk("R12 busy", {31'b0, m_req}, 32'h1);
    wr_reg(2'd1, 32'h0999);
    wr_reg(2'd0, 32'h0000_0000);
    wr_reg(2'd2, 32'h5555_1111);
    chk("R12 wdata kept", m_wdata, 32'hAAAA_0000);
    m_ack = 1'b1;
    @(negedge clk);
    m_ack = 1'b0;
    rd_reg(2'd1, v); chk("R12 addr kept", v, 32'h0040);
    rd_reg(2'd0, v); chk("R12 ctl kept", v, 32'h3000_6042);
    rd_reg(2'd2, v); chk("R12 data kept", v, 32'hAAAA_0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_raz();
    t_status();
    dbg_en = 1'b1;
    t_dev_off();
    t_write_nonsecure();
    t_secure();
    t_increment();
    t_format();
    t_stop();
    t_npass();
    t_busy_ignore();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule